// File: doc/BRIEF.md
# Ripple-Aware Cell Insertion Selector

This block chooses, once per control period, which H-bridge cells of one series-connected phase leg are fully inserted, which single cell carries the fractional PWM pulse, and the polarity of both. A signed voltage reference, in units of one cell voltage with 8 fractional bits, is split into a whole count of cells and a fractional duty. The cells are then ranked by their capacitor voltages. In a discharging half period, the fullest cells are inserted. In a charging half period, the emptiest ones are inserted.

Two strobes drive the block. `main_evt` marks the carrier top or bottom; at that point the reference, the cell voltages and the current measurements are captured. `mid_evt` marks the point halfway between two main events. When the current RMS is below a small threshold, the leg is in standby. In standby, the measured current sign is not trusted: the first half of the period uses a fixed direction, and the mid event flips it. The partial pulse is therefore started by one cell and finished by another, and the reference and whole-cell count stay untouched. Outside standby, the direction comes from the measured current sign against the reference polarity, and the mid event changes nothing.

The strobes are single-cycle control pulses, not a stream, so the block has no handshake. Its outputs are registered and change one clock after the edge that sees an event.

Top module: `rcs_sort_selector`

## Requirements
- R1: After reset, every cell state is 0 (code 2'b00), and `frac_valid`, `frac_idx`, `frac_duty`, `frac_neg`, `charging` and `standby` are all 0.
- R2: With m = |v_ref| (two's complement, 8 fractional bits), the number of nonzero cell states is floor(m/256) clamped to N_CELLS, and `frac_duty` is m mod 256. When the count clamps, `frac_duty` is 0. `frac_valid` is 1 exactly when `frac_duty` is nonzero.
- R3: Every inserted cell carries code 2'b01 (+1) when v_ref >= 0 and code 2'b11 (-1) when v_ref < 0. `frac_neg` equals the sign bit of the captured reference.
- R4: In a discharging half (`charging`=0), cells are ordered by descending voltage, with ties going to the lower index. The first count cells in that order are inserted, and the next cell is `frac_idx`.
- R5: In a charging half (`charging`=1), the order is ascending voltage, with ties going to the lower index. Insertion and fractional choice follow the same rule as in R4.
- R6: Standby is flagged at a main event when `i_rms` < STBY_THRESH (default 983, that is 0.03 in Q1.15 per-unit). In standby, the first half is discharging when `dly_cfg`=0 and charging when `dly_cfg`=1, whatever the sign of the reference or the current.
- R7: In standby, the first `mid_evt` after a main event flips `charging`. The whole-cell count, `frac_duty` and `frac_neg` stay unchanged. A further `mid_evt` before the next main event has no effect.
- R8: Outside standby, `charging` = (`i_neg` == sign of v_ref), and `mid_evt` leaves every output unchanged.
- R9: Ranking uses the cell voltages captured at the main event. Changes on `cell_v` between events do not affect the outputs.
- R10: Outputs change on the clock edge after the one that samples an event. When `main_evt` and `mid_evt` are high together, the main event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_evt | input | 1 | Carrier top/bottom strobe: capture and first-half decision |
| mid_evt | input | 1 | Mid-period strobe: second-half re-sort in standby |
| dly_cfg | input | 1 | 1 = controller has a one-sample delay (charge first in standby) |
| v_ref | input | 16 | Signed reference, cell-voltage units, 8 fractional bits |
| cell_v | input | 144 | Packed unsigned 16-bit capacitor voltages, cell i at [16i+15:16i] |
| i_rms | input | 16 | Current RMS, Q1.15 per-unit |
| i_neg | input | 1 | Instantaneous current sign, 1 = negative |
| cell_state | output | 18 | Two bits per cell: 00 off, 01 +1, 11 -1 |
| frac_valid | output | 1 | A fractional pulse is requested |
| frac_idx | output | 4 | Cell carrying the fractional pulse |
| frac_duty | output | 8 | Fractional pulse duty, units of 1/256 |
| frac_neg | output | 1 | Polarity of the fractional pulse |
| charging | output | 1 | Current half period treated as charging |
| standby | output | 1 | Zero-current mode active for this period |

## Verification
The assertions assume that `mid_evt` arrives only after a main event. They also assume that the ranking is a true permutation, so that exactly one cell holds rank zero even when voltages tie. Neither assumption holds trivially before the first main event. The stimulus therefore always issues a main event before any mid event, separates events by at least two clocks, and draws voltage sets both from a narrow band, which forces many ties, and from the full range. The only exceptions are the deliberate simultaneous-strobe and repeated-mid cases, which the checks predict explicitly.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_POS = 2'b01,
    ST_NEG = 2'b11
  } cell_st_e;
endpackage

// File: rtl/rcs_ref_split.sv
module rcs_ref_split #(
  parameter int N_CELLS = 9,
  parameter int REF_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
  input  logic signed [REF_W-1:0] ref_in,
  output logic [CNT_W-1:0]        whole,
  output logic [FRAC_W-1:0]       frac,
  output logic                    neg
);
  localparam int MAG_W = REF_W + 1;
  localparam int INT_W = MAG_W - FRAC_W;

  logic [MAG_W-1:0] mag;
  logic [INT_W-1:0] ipart;

  always_comb begin
    neg = ref_in[REF_W-1];
    if (neg) mag = -{ref_in[REF_W-1], ref_in};
    else     mag = {1'b0, ref_in};
    ipart = mag[MAG_W-1:FRAC_W];
    if (ipart >= INT_W'(N_CELLS)) begin
      whole = CNT_W'(N_CELLS);
      frac  = '0;
    end else begin
      whole = ipart[CNT_W-1:0];
      frac  = mag[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/rcs_mode_ctrl.sv
module rcs_mode_ctrl #(
  parameter int RMS_W       = 16,
  parameter int STBY_THRESH = 983
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_evt,
  input  logic             mid_evt,
  input  logic             dly_cfg,
  input  logic [RMS_W-1:0] i_rms,
  input  logic             i_neg,
  input  logic             ref_neg,
  output logic             standby_q,
  output logic             charging_q,
  output logic             half_q
);
  logic stby_now;
  assign stby_now = (i_rms < RMS_W'(STBY_THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      standby_q  <= 1'b0;
      charging_q <= 1'b0;
      half_q     <= 1'b0;
    end else if (main_evt) begin
      standby_q  <= stby_now;
      half_q     <= 1'b0;
      charging_q <= stby_now ? dly_cfg : (i_neg == ref_neg);
    end else if (mid_evt && !half_q) begin
      half_q <= 1'b1;
      if (standby_q) charging_q <= ~charging_q;
    end
  end

  assert_mid_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && !main_evt && !half_q && standby_q) |=> (charging_q != $past(charging_q)));
  assert_classic_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && !main_evt && !standby_q) |=> $stable(charging_q));
  assert_second_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && !main_evt && half_q) |=> $stable(charging_q) && $stable(standby_q));
  assert_stby_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_evt && stby_now) |=> (standby_q && charging_q == $past(dly_cfg)));
endmodule

// File: rtl/rcs_rank.sv
module rcs_rank #(
  parameter int N_CELLS = 9,
  parameter int VW      = 16,
  parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
  input  logic [N_CELLS*VW-1:0]    volts,
  input  logic                     charging,
  output logic [N_CELLS*CNT_W-1:0] ranks
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic [CNT_W-1:0] cnt;
    logic [VW-1:0]    vi;
    assign vi = volts[i*VW +: VW];
    always_comb begin
      cnt = '0;
      for (int j = 0; j < N_CELLS; j++) begin
        if (j != i) begin
          if (charging ? (volts[j*VW +: VW] < vi) : (volts[j*VW +: VW] > vi))
            cnt = cnt + 1'b1;
          else if ((volts[j*VW +: VW] == vi) && (j < i))
            cnt = cnt + 1'b1;
        end
      end
    end
    assign ranks[i*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/rcs_sort_selector.sv
module rcs_sort_selector #(
  parameter int N_CELLS     = 9,
  parameter int VW          = 16,
  parameter int REF_W       = 16,
  parameter int FRAC_W      = 8,
  parameter int RMS_W       = 16,
  parameter int STBY_THRESH = 983,
  parameter int IDX_W       = $clog2(N_CELLS),
  parameter int CNT_W       = $clog2(N_CELLS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    main_evt,
  input  logic                    mid_evt,
  input  logic                    dly_cfg,
  input  logic signed [REF_W-1:0] v_ref,
  input  logic [N_CELLS*VW-1:0]   cell_v,
  input  logic [RMS_W-1:0]        i_rms,
  input  logic                    i_neg,
  output logic [2*N_CELLS-1:0]    cell_state,
  output logic                    frac_valid,
  output logic [IDX_W-1:0]        frac_idx,
  output logic [FRAC_W-1:0]       frac_duty,
  output logic                    frac_neg,
  output logic                    charging,
  output logic                    standby
);
  import rcs_pkg::*;

  logic [CNT_W-1:0]         whole_d, whole_q;
  logic [FRAC_W-1:0]        frac_d, frac_q;
  logic                     neg_d, neg_q;
  logic [N_CELLS*VW-1:0]    volts_q;
  logic                     standby_q, charging_q, half_q;
  logic [N_CELLS*CNT_W-1:0] ranks;
  logic [N_CELLS-1:0]       ins_mask, frac_mask, zero_mask;
  logic [IDX_W-1:0]         frac_idx_d;
  logic [N_CELLS-1:0]       ins_bits_q, neg_bits_q;

  rcs_ref_split #(.N_CELLS(N_CELLS), .REF_W(REF_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) split_i (
    .ref_in(v_ref), .whole(whole_d), .frac(frac_d), .neg(neg_d)
  );

  rcs_mode_ctrl #(.RMS_W(RMS_W), .STBY_THRESH(STBY_THRESH)) mode_i (
    .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .mid_evt(mid_evt),
    .dly_cfg(dly_cfg), .i_rms(i_rms), .i_neg(i_neg), .ref_neg(neg_d),
    .standby_q(standby_q), .charging_q(charging_q), .half_q(half_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      whole_q <= '0;
      frac_q  <= '0;
      neg_q   <= 1'b0;
      volts_q <= '0;
    end else if (main_evt) begin
      whole_q <= whole_d;
      frac_q  <= frac_d;
      neg_q   <= neg_d;
      volts_q <= cell_v;
    end
  end

  rcs_rank #(.N_CELLS(N_CELLS), .VW(VW), .CNT_W(CNT_W)) rank_i (
    .volts(volts_q), .charging(charging_q), .ranks(ranks)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
    assign ins_mask[i]  = ranks[i*CNT_W +: CNT_W] < whole_q;
    assign frac_mask[i] = (ranks[i*CNT_W +: CNT_W] == whole_q) && (frac_q != '0);
    assign zero_mask[i] = ranks[i*CNT_W +: CNT_W] == '0;
    assign ins_bits_q[i] = cell_state[2*i];
    assign neg_bits_q[i] = cell_state[2*i+1];
  end

  always_comb begin
    frac_idx_d = '0;
    for (int i = 0; i < N_CELLS; i++)
      if (frac_mask[i]) frac_idx_d = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_state <= '0;
      frac_valid <= 1'b0;
      frac_idx   <= '0;
      frac_duty  <= '0;
      frac_neg   <= 1'b0;
      charging   <= 1'b0;
      standby    <= 1'b0;
    end else begin
      for (int i = 0; i < N_CELLS; i++)
        cell_state[2*i +: 2] <= ins_mask[i] ? (neg_q ? ST_NEG : ST_POS) : ST_OFF;
      frac_valid <= |frac_mask;
      frac_idx   <= frac_idx_d;
      frac_duty  <= frac_q;
      frac_neg   <= neg_q;
      charging   <= charging_q;
      standby    <= standby_q;
    end
  end

  assert_ins_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ins_bits_q) == $past(whole_q));
  assert_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    neg_bits_q == (ins_bits_q & {N_CELLS{frac_neg}}));
  assert_frac_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(frac_mask) && !(|(frac_mask & ins_mask)));
  assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(zero_mask));
  assert_hold_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && !main_evt) |=> $stable(whole_q) && $stable(frac_q) && $stable(neg_q));
  assert_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !main_evt |=> $stable(volts_q));
endmodule

// File: tb/rcs_sort_selector_tb.sv
module rcs_sort_selector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;
  localparam int THR = 983;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_evt = 1'b0, mid_evt = 1'b0, dly_cfg = 1'b0, i_neg = 1'b0;
  logic signed [15:0] v_ref = '0;
  logic [N*16-1:0] cell_v = '0;
  logic [15:0] i_rms = '0;
  logic [2*N-1:0] cell_state;
  logic frac_valid, frac_neg, charging, standby;
  logic [3:0] frac_idx;
  logic [7:0] frac_duty;

  int applied = 0, bad = 0;
  bit done = 0;
  int vv[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rcs_sort_selector dut_i (
    .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .mid_evt(mid_evt),
    .dly_cfg(dly_cfg), .v_ref(v_ref), .cell_v(cell_v), .i_rms(i_rms),
    .i_neg(i_neg), .cell_state(cell_state), .frac_valid(frac_valid),
    .frac_idx(frac_idx), .frac_duty(frac_duty), .frac_neg(frac_neg),
    .charging(charging), .standby(standby)
  );

  task automatic chk(string tag, int act, int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_volts(bit narrow);
    for (int i = 0; i < N; i++) begin
      vv[i] = narrow ? (1000 + int'($urandom % 4)) : int'($urandom % 65536);
      cell_v[16*i +: 16] = 16'(vv[i]);
    end
  endtask

  // expected outputs for one half period, from captured voltages
  task automatic expect_half(int r, bit chg, bit stby, string tag);
    int mag, ip, fr, best;
    bit used[N];
    int order[N];
    logic [2*N-1:0] exp_st;
    mag = (r < 0) ? -r : r;
    ip = mag / 256; fr = mag % 256;
    if (ip >= N) begin ip = N; fr = 0; end
    for (int i = 0; i < N; i++) used[i] = 0;
    for (int k = 0; k < N; k++) begin
      best = -1;
      for (int j = 0; j < N; j++)
        if (!used[j] && (best < 0 || (chg ? vv[j] < vv[best] : vv[j] > vv[best]))) best = j;
      used[best] = 1;
      order[k] = best;
    end
    exp_st = '0;
    for (int k = 0; k < ip; k++) exp_st[2*order[k] +: 2] = (r < 0) ? 2'b11 : 2'b01;
    chk({tag, " R2 count"}, $countones(cell_state & {N{2'b01}}), ip);
    chk({tag, " R2 duty"}, frac_duty, fr);
    chk({tag, " R2 fvalid"}, frac_valid, fr != 0);
    chk({tag, " R3 fneg"}, frac_neg, r < 0);
    chk({tag, chg ? " R5 states" : " R4 states"}, cell_state, exp_st);
    if (fr != 0) chk({tag, chg ? " R5 fidx" : " R4 fidx"}, frac_idx, order[ip]);
    chk({tag, " R6 R8 mode"}, charging, chg);
    chk({tag, " R6 standby"}, standby, stby);
  endtask

  task automatic pulse(bit mn, bit md);
    @(negedge clk); main_evt = mn; mid_evt = md;
    @(negedge clk); main_evt = 0; mid_evt = 0;
    @(negedge clk);
  endtask

  task automatic run_vec(int r, int rms, bit ineg, bit dly, bit narrow);
    bit stby, m1, m2;
    v_ref = 16'(r); i_rms = 16'(rms); i_neg = ineg; dly_cfg = dly;
    load_volts(narrow);
    stby = rms < THR;
    m1 = stby ? dly : (ineg == (r < 0));
    pulse(1, 0);
    expect_half(r, m1, stby, "first R10");
    // disturb inputs before the mid event (R9)
    v_ref = 16'(-r); i_neg = ~ineg; i_rms = 16'(stby ? 40000 : 0);
    for (int i = 0; i < N; i++) cell_v[16*i +: 16] = 16'($urandom);
    m2 = stby ? ~m1 : m1;
    pulse(0, 1);
    expect_half(r, m2, stby, "mid R7 R9");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      bad++;
      applied++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    int rl[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", cell_state, 0);
    chk("R1 fvalid", frac_valid, 0);
    chk("R1 fidx", frac_idx, 0);
    chk("R1 duty", frac_duty, 0);
    chk("R1 fneg", frac_neg, 0);
    chk("R1 mode", charging, 0);
    chk("R1 stby", standby, 0);

    rl = '{0, 1, 255, 256, 257, -1, -256, -257, 2303, 2304, 2305, -2304, -2305,
           32767, -32768, 512, -1792};
    for (int r = -2600; r <= 2600; r += 41) rl.push_back(r);
    foreach (rl[k])
      for (int c = 0; c < 8; c++) begin
        int rms;
        rms = (c[2]) ? ((c[0]) ? 0 : THR - 1) : ((c[0]) ? THR : 5000);
        run_vec(rl[k], rms, c[1], c[0] ^ c[1], k[0]);
      end

    // R7 second mid has no effect
    run_vec(600, 10, 0, 0, 1);
    pulse(0, 1);
    expect_half(600, 1, 1, "second mid R7");

    // R10 simultaneous strobes: main wins
    v_ref = 16'sd700; i_rms = 16'd5; dly_cfg = 0; i_neg = 0;
    load_volts(0);
    pulse(1, 1);
    expect_half(700, 0, 1, "both R10");
    pulse(0, 1);
    expect_half(700, 1, 1, "after both R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule